// File: doc/BRIEF.md
# Clock Divider Setting Search

This unit chooses the settings for a two-stage clock divide chain. Given a parent clock frequency and a wanted output frequency, both as 32-bit unsigned integers, it tries every pair of settings (M, N). For each pair it computes the frequency the chain would produce, using truncating integer arithmetic. It then reports the pair whose frequency lies closest to the target without going above it. A fixed prescale factor and the offset added to M are set when the block is elaborated. An offset of zero stops elaboration, because the divisor for M = 0 would then be zero.

The chain that is modelled runs in this order: the parent is divided by the prescale, then divided by ten, then shifted right by N, then divided by (M + offset). A single sequential restoring divider does all of this work. It first forms the common quotient parent / (prescale x 10) once. It then evaluates each candidate in turn, spending one divider pass on each. Software or a boot sequencer pulses start, waits for done, and reads the frequency and the two settings. These results stay on the outputs until the next accepted start.

Top module: `clkdiv_search`

## Requirements
- R1: The frequency of a candidate is ((parent / PREDIV) / 10 >> N) / (M + M_OFFSET), where every step truncates toward zero. The reported frequency is the frequency of the reported (M, N) pair.
- R2: A candidate whose frequency is greater than the target is never chosen, so the reported frequency is never above the target.
- R3: Candidates are visited with M going from 0 to 7 in the outer loop and N going from 0 to 7 in the inner loop, so N changes fastest. A candidate replaces the held best only when target minus its frequency is strictly smaller than target minus the best frequency. On a tie, the pair visited first is kept.
- R4: The best starts at frequency 0 with M = 0 and N = 0. If no candidate improves on that, the result is frequency 0, M = 0, N = 0. This includes a target of 0.
- R5: A start that arrives while busy is high has no effect. The run in progress finishes with the result for the parent and target captured when it started.
- R6: busy goes high in the cycle after an accepted start. done is high for exactly one cycle at the end of the search, and busy is low in the cycle after done.
- R7: While the unit is idle and start is low, the result outputs stay the same, even when the parent and target inputs change.
- R8: After reset, busy, done, the frequency, M and N are all 0.
- R9: Parent and target values cover the full 32-bit range, including 0xFFFFFFFF, and no intermediate value wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Starts a search when the unit is idle; sampled on the rising edge |
| parent_i | input | 32 | Parent clock frequency, captured at an accepted start |
| target_i | input | 32 | Wanted output frequency, captured at an accepted start |
| busy_o | output | 1 | A search is in progress |
| done_o | output | 1 | One-cycle pulse when the search ends |
| freq_o | output | 32 | Best frequency found |
| m_o | output | 3 | Chosen M setting |
| n_o | output | 3 | Chosen N setting |

## Verification
The bench builds the unit with PREDIV = 3 and M_OFFSET = 1. A prescale that is not a power of two makes the truncation in the shared quotient visible. An offset of one turns M = 0 into a divide by one, so a shift by N and a divide by (M + 1) can give the same frequency. That makes first-visited tie-breaking easy to provoke on purpose: a parent of 600 with a target of 10 must return M = 0, N = 1. The expected results come from a loop in the bench that follows the requirements. They are compared for tabulated and random parent and target values, for an all-ones parent and target, for a zero target, and for targets below every non-zero candidate.

// File: rtl/clkdiv_search_pkg.sv
package clkdiv_search_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BASE,
    ST_CAND,
    ST_WAIT,
    ST_DONE
  } scan_state_e;

endpackage

// File: rtl/clkdiv_serdiv.sv
module clkdiv_serdiv #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         done_o,
  output logic [W-1:0] quot_o
);

  localparam int CW = $clog2(W + 1);
  localparam int W2 = 2 * W;

  logic [W-1:0]  rem_q, rem_n;
  logic [W-1:0]  quo_q, quo_n;
  logic [W-1:0]  dvs_q, dvs_n;
  logic [W-1:0]  dvd_q, dvd_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          run_q, run_n;
  logic          done_q, done_n;
  logic [W:0]    shifted, trial;

  always_comb begin
    rem_n   = rem_q;
    quo_n   = quo_q;
    dvs_n   = dvs_q;
    dvd_n   = dvd_q;
    cnt_n   = cnt_q;
    run_n   = run_q;
    done_n  = 1'b0;
    shifted = {rem_q, quo_q[W-1]};
    trial   = shifted - {1'b0, dvs_q};
    if (start_i && !run_q) begin
      rem_n = '0;
      quo_n = dividend_i;
      dvs_n = divisor_i;
      dvd_n = dividend_i;
      cnt_n = CW'(W);
      run_n = 1'b1;
    end else if (run_q) begin
      if (!trial[W]) begin
        rem_n = trial[W-1:0];
        quo_n = {quo_q[W-2:0], 1'b1};
      end else begin
        rem_n = shifted[W-1:0];
        quo_n = {quo_q[W-2:0], 1'b0};
      end
      cnt_n = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        run_n  = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      dvd_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_n;
      quo_q  <= quo_n;
      dvs_q  <= dvs_n;
      dvd_q  <= dvd_n;
      cnt_q  <= cnt_n;
      run_q  <= run_n;
      done_q <= done_n;
    end
  end

  assign done_o = done_q;
  assign quot_o = quo_q;

  // R1: the quotient handed out is the truncated quotient of the captured operands
  p_div_quot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ((W2'(quo_q) * W2'(dvs_q) <= W2'(dvd_q)) &&
                (W2'(dvd_q) - W2'(quo_q) * W2'(dvs_q) < W2'(dvs_q))));

endmodule

// File: rtl/clkdiv_best.sv
module clkdiv_best #(
  parameter int W  = 32,
  parameter int MW = 3,
  parameter int NW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          valid_i,
  input  logic [W-1:0]  cand_i,
  input  logic [MW-1:0] m_i,
  input  logic [NW-1:0] n_i,
  input  logic [W-1:0]  target_i,
  output logic [W-1:0]  freq_o,
  output logic [MW-1:0] m_o,
  output logic [NW-1:0] n_o
);

  logic [W-1:0]  freq_q, freq_n;
  logic [MW-1:0] m_q, m_n;
  logic [NW-1:0] n_q, n_n;
  logic [W-1:0]  gap_cand, gap_best;
  logic          fits, closer;

  always_comb begin
    fits     = cand_i <= target_i;
    gap_cand = target_i - cand_i;
    gap_best = target_i - freq_q;
    closer   = gap_cand < gap_best;
    freq_n   = freq_q;
    m_n      = m_q;
    n_n      = n_q;
    if (clear_i) begin
      freq_n = '0;
      m_n    = '0;
      n_n    = '0;
    end else if (valid_i && fits && closer) begin
      freq_n = cand_i;
      m_n    = m_i;
      n_n    = n_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_q <= '0;
      m_q    <= '0;
      n_q    <= '0;
    end else begin
      freq_q <= freq_n;
      m_q    <= m_n;
      n_q    <= n_n;
    end
  end

  assign freq_o = freq_q;
  assign m_o    = m_q;
  assign n_o    = n_q;

  // R3: an offered candidate can only move the best closer to the target
  p_best_grows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !clear_i) |=> (freq_q >= $past(freq_q)));

endmodule

// File: rtl/clkdiv_search.sv
module clkdiv_search
  import clkdiv_search_pkg::*;
#(
  parameter int W        = 32,
  parameter int PREDIV   = 1,
  parameter int M_OFFSET = 1,
  parameter int M_STEPS  = 8,
  parameter int N_STEPS  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic [W-1:0]                 parent_i,
  input  logic [W-1:0]                 target_i,
  output logic                         busy_o,
  output logic                         done_o,
  output logic [W-1:0]                 freq_o,
  output logic [$clog2(M_STEPS)-1:0]   m_o,
  output logic [$clog2(N_STEPS)-1:0]   n_o
);

  localparam int MW = $clog2(M_STEPS);
  localparam int NW = $clog2(N_STEPS);
  localparam logic [W-1:0] BASE_DIV = W'(PREDIV * 10);

  generate
    if (M_OFFSET < 1) begin : g_bad_offset
      $error("M_OFFSET must be at least 1");
    end
    if (PREDIV < 1) begin : g_bad_prediv
      $error("PREDIV must be at least 1");
    end
  endgenerate

  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  scan_state_e   state_q, state_n;
  logic [W-1:0]  base_q, base_n;
  logic [W-1:0]  target_q, target_n;
  logic [MW-1:0] m_q, m_n;
  logic [NW-1:0] n_q, n_n;
  logic          accept, last_cand;
  logic          div_start, div_done;
  logic [W-1:0]  div_dvd, div_dvs, div_quot;
  logic          cand_valid;

  assign accept    = (state_q == ST_IDLE) && start_i;
  assign last_cand = (m_q == MW'(M_STEPS - 1)) && (n_q == NW'(N_STEPS - 1));

  always_comb begin
    state_n    = state_q;
    base_n     = base_q;
    target_n   = target_q;
    m_n        = m_q;
    n_n        = n_q;
    div_start  = 1'b0;
    div_dvd    = base_q >> n_q;
    div_dvs    = W'(m_q) + W'(M_OFFSET);
    cand_valid = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i) begin
        div_start = 1'b1;
        div_dvd   = parent_i;
        div_dvs   = BASE_DIV;
        target_n  = target_i;
        m_n       = '0;
        n_n       = '0;
        state_n   = ST_BASE;
      end
      ST_BASE: if (div_done) begin
        base_n  = div_quot;
        state_n = ST_CAND;
      end
      ST_CAND: begin
        div_start = 1'b1;
        state_n   = ST_WAIT;
      end
      ST_WAIT: if (div_done) begin
        cand_valid = 1'b1;
        if (last_cand) begin
          state_n = ST_DONE;
        end else if (n_q == NW'(N_STEPS - 1)) begin
          n_n     = '0;
          m_n     = m_q + 1'b1;
          state_n = ST_CAND;
        end else begin
          n_n     = n_q + 1'b1;
          state_n = ST_CAND;
        end
      end
      ST_DONE: state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q  <= ST_IDLE;
      base_q   <= '0;
      target_q <= '0;
      m_q      <= '0;
      n_q      <= '0;
    end else begin
      state_q  <= state_n;
      base_q   <= base_n;
      target_q <= target_n;
      m_q      <= m_n;
      n_q      <= n_n;
    end
  end

  clkdiv_serdiv #(.W(W)) i_div (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_i    (div_start),
    .dividend_i (div_dvd),
    .divisor_i  (div_dvs),
    .done_o     (div_done),
    .quot_o     (div_quot)
  );

  clkdiv_best #(.W(W), .MW(MW), .NW(NW)) i_best (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clear_i  (accept),
    .valid_i  (cand_valid),
    .cand_i   (div_quot),
    .m_i      (m_q),
    .n_i      (n_q),
    .target_i (target_q),
    .freq_o   (freq_o),
    .m_o      (m_o),
    .n_o      (n_o)
  );

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_DONE);

  // R2: the held best never exceeds the captured target
  p_below_target_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    freq_o <= target_q);

  // R5: a start during a run leaves the captured target alone
  p_start_ignored_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy_o && !done_o && start_i) |=> $stable(target_q));

  // R6: done lasts one cycle and the unit is idle right after
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |=> (!done_o && !busy_o));

  // R7: idle with no start keeps the results steady
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!busy_o && !start_i) |=> ($stable(freq_o) && $stable(m_o) && $stable(n_o)));

endmodule

// File: tb/test_clkdiv_search.sv
`timescale 1ns/1ps
module test_clkdiv_search;

  localparam int PD  = 3;
  localparam int OFS = 1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [31:0] parent_i, target_i;
  logic        busy_o, done_o;
  logic [31:0] freq_o;
  logic [2:0]  m_o, n_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  clkdiv_search #(.W(32), .PREDIV(PD), .M_OFFSET(OFS)) i_clkdiv_search (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .parent_i (parent_i),
    .target_i (target_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .freq_o   (freq_o),
    .m_o      (m_o),
    .n_o      (n_o)
  );

  // stimulus: {parent, target}
  localparam logic [63:0] VEC [12] = '{
    {32'd24000000, 32'd100000},
    {32'd297000000, 32'd400000},
    {32'd600, 32'd7},
    {32'd12345678, 32'd9999},
    {32'd1000, 32'd33},
    {32'd300000, 32'd5000},
    {32'd99, 32'd1},
    {32'd7777777, 32'd300000},
    {32'd150000000, 32'd100},
    {32'd3000, 32'd13},
    {32'd65535, 32'd500},
    {32'd1, 32'd1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ref_search(input logic [31:0] p, input logic [31:0] t,
                            output logic [31:0] bf, output logic [2:0] bm, output logic [2:0] bn);
    logic [31:0] base;
    base = (p / PD) / 10;
    bf = 0; bm = 0; bn = 0;
    for (int m = 0; m < 8; m++) begin
      for (int n = 0; n < 8; n++) begin
        logic [31:0] f;
        f = (base >> n) / (m + OFS);
        if (f <= t && (t - f) < (t - bf)) begin
          bf = f; bm = 3'(m); bn = 3'(n);
        end
      end
    end
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done_o) begin ok = 1; break; end
    end
  endtask

  task automatic run(input logic [31:0] p, input logic [31:0] t, input string tag);
    logic [31:0] ef; logic [2:0] em, en; bit ok;
    ref_search(p, t, ef, em, en);
    @(negedge clk);
    parent_i = p; target_i = t; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk({tag, " R6 busy after start"}, 32'(busy_o), 32'd1);
    wait_done(ok);
    chk({tag, " R6 done seen"}, 32'(ok), 32'd1);
    chk({tag, " R1 freq"}, freq_o, ef);
    chk({tag, " R3 m"}, 32'(m_o), 32'(em));
    chk({tag, " R3 n"}, 32'(n_o), 32'(en));
    chk({tag, " R2 freq<=target"}, 32'(freq_o <= t), 32'd1);
    @(negedge clk);
    chk({tag, " R6 done one cycle"}, 32'(done_o), 32'd0);
    chk({tag, " R6 idle after done"}, 32'(busy_o), 32'd0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=<190000", cycles);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] f0; logic [2:0] m0, n0;
    logic [31:0] ef; logic [2:0] em, en; bit ok;
    rst_n = 1'b0; start_i = 1'b0; parent_i = '0; target_i = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R8 reset state
    chk("R8 busy", 32'(busy_o), 32'd0);
    chk("R8 done", 32'(done_o), 32'd0);
    chk("R8 freq", freq_o, 32'd0);
    chk("R8 m", 32'(m_o), 32'd0);
    chk("R8 n", 32'(n_o), 32'd0);

    for (int i = 0; i < 12; i++) run(VEC[i][63:32], VEC[i][31:0], "table");
    for (int i = 0; i < 8; i++) run($urandom, $urandom >> ($urandom % 32), "random");

    // R3 tie: base 20, target 10 -> M0N1 visited before M1N0
    run(32'd600, 32'd10, "tie");
    chk("R3 tie picks first m", 32'(m_o), 32'd0);
    chk("R3 tie picks first n", 32'(n_o), 32'd1);

    // R4 zero target and target below every non-zero candidate
    run(32'd5000, 32'd0, "zero target");
    chk("R4 zero target freq", freq_o, 32'd0);
    chk("R4 zero target m", 32'(m_o), 32'd0);
    run(32'd29, 32'd5, "no candidate");
    chk("R4 none qualifies n", 32'(n_o), 32'd0);

    // R9 full range
    run(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R9 max");
    chk("R9 max freq", freq_o, 32'd143165576);

    // R7 hold while idle with moving inputs
    f0 = freq_o; m0 = m_o; n0 = n_o;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      parent_i = $urandom; target_i = $urandom;
    end
    chk("R7 freq held", freq_o, f0);
    chk("R7 m held", 32'(m_o), 32'(m0));
    chk("R7 n held", 32'(n_o), 32'(n0));

    // R5 start during a run is ignored
    ref_search(32'd297000000, 32'd123456, ef, em, en);
    @(negedge clk);
    parent_i = 32'd297000000; target_i = 32'd123456; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (100) @(negedge clk);
    parent_i = 32'd1000; target_i = 32'd3; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done(ok);
    chk("R5 run finished", 32'(ok), 32'd1);
    chk("R5 freq unaffected", freq_o, ef);
    chk("R5 m unaffected", 32'(m_o), 32'(em));
    chk("R5 n unaffected", 32'(n_o), 32'(en));
    @(negedge clk);
    chk("R5 no second run", 32'(busy_o), 32'd0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule